// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between a CPU bus and a cartridge's ROM and external RAM. The CPU writes into the ROM address space, and the block decodes those writes as control accesses using address bits [15:13] (the region). From them it keeps four pieces of state: a five-bit low bank field, a two-bit upper bank field, a banking-mode bit and a RAM-enable flag. It drives no data. For each CPU read it supplies the high address bits of the physical ROM or RAM location, and it says whether the RAM window may be accessed or must read as 0xFF.

A parameter sets the ROM size in 16 KiB banks and another sets the RAM size in 8 KiB banks. Both must be powers of two, the ROM at least 2 banks and the RAM at least 2 banks. A third parameter selects the multi-game layout. In that layout the upper bank field sits at bit 4 of the bank number instead of bit 5, and the low bank field is cut to four bits. All outputs are combinational in the registered state and the current region. A change of state is therefore visible to the next read after the clock edge that takes the write.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the switchable bank is 1, the low region maps to bank 0, the RAM bank is 0, RAM is disabled and the mode is 0.
- R2: A write to region 0 with data 0x0A enables RAM and with data 0x00 disables it; any other data value leaves the enable as it was.
- R3: A write to region 1 takes data bits [4:0] as the low bank field. A zero is replaced by 1 first, and only then is the field masked to 5 bits (normal) or 4 bits (multi-game), so multi-game data 0x10 gives field 0.
- R4: A write to region 2 stores data bits [1:0] as the upper field. The switchable bank is (upper << S) | low, with S = 5 normally and 4 in multi-game layout. The low field keeps its value.
- R5: With mode 1, the low region (regions 0 and 1) maps to ROM bank upper << S, and the RAM bank equals the upper field.
- R6: With mode 0, the low region maps to ROM bank 0 and the RAM bank is 0, while the upper field still applies to the switchable bank.
- R7: ROM bank numbers wrap by masking with ROM_BANKS-1, and RAM bank numbers wrap by masking with RAM_BANKS-1.
- R8: A write to region 3 sets the mode from data bit 0. romSel is 1 for regions 0 to 3. romBank gives the low-region bank when region bit 1 is 0 and the switchable bank when it is 1.
- R9: In region 5, ramSel is 1 and ramBlank is 0 when RAM is enabled. When RAM is disabled, ramSel is 0 and ramBlank is 1, and the bus must then return 0xFF. Outside region 5 both are 0.
- R10: A cycle with wrEn low, or a write to regions 4 to 7, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | CPU write strobe, one cycle per write |
| cpuRegion | input | 3 | CPU address bits [15:13] |
| wrData | input | 8 | CPU write data |
| romBank | output | ROM_BW | Physical ROM bank for the current read |
| ramBank | output | RAM_BW | Physical RAM bank |
| romSel | output | 1 | Current region is ROM |
| ramSel | output | 1 | RAM window access is allowed |
| ramBlank | output | 1 | RAM window is disabled; the read returns 0xFF |

## Verification
The bench targets the remap-before-mask ordering. Data 0x20 must still give bank 1 in the normal layout, and data 0x10 must give bank 0 in the multi-game layout; a design that masks first would put a 1 in the multi-game case. It checks that an enable value merely close to 0x0A (0x1A) is ignored, that upper bits set in mode 0 leave the low region at bank 0, and that mode 1 moves both the low region and the RAM bank. Bank numbers past the ROM and RAM sizes must wrap, and a design that dropped the mask would present out-of-range banks. A second instance with 4-bit stride, 32 ROM banks and 2 RAM banks catches a shift hard-wired to 5.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  localparam logic [2:0] REGION_RAM_EN = 3'd0;
  localparam logic [2:0] REGION_LOW    = 3'd1;
  localparam logic [2:0] REGION_UPPER  = 3'd2;
  localparam logic [2:0] REGION_MODE   = 3'd3;
  localparam logic [2:0] REGION_RAMWIN = 3'd5;

  localparam logic [7:0] RAM_ON_CODE  = 8'h0A;
  localparam logic [7:0] RAM_OFF_CODE = 8'h00;

  typedef struct packed {
    logic       ramOn;
    logic       ramOff;
    logic       lowLd;
    logic       upperLd;
    logic       modeLd;
    logic [4:0] lowVal;
    logic [1:0] upperVal;
    logic       modeVal;
  } bankStrobe_t;

endpackage

// File: rtl/cart_bank_decode.sv
module cart_bank_decode
  import cart_bank_pkg::*;
#(
  parameter int MULTICART = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  cpuRegion,
  input  logic [7:0]  wrData,
  output bankStrobe_t strobe
);

  localparam logic [4:0] LOW_MASK = (MULTICART != 0) ? 5'h0F : 5'h1F;

  logic [4:0] lowRaw;

  always_comb begin
    lowRaw = wrData[4:0];
    if (lowRaw == 5'd0) lowRaw = 5'd1;   // zero remap precedes the stride mask
    strobe          = '0;
    strobe.lowVal   = lowRaw & LOW_MASK;
    strobe.upperVal = wrData[1:0];
    strobe.modeVal  = wrData[0];
    if (wrEn) begin
      case (cpuRegion)
        REGION_RAM_EN: begin
          strobe.ramOn  = (wrData == RAM_ON_CODE);
          strobe.ramOff = (wrData == RAM_OFF_CODE);
        end
        REGION_LOW:   strobe.lowLd   = 1'b1;
        REGION_UPPER: strobe.upperLd = 1'b1;
        REGION_MODE:  strobe.modeLd  = 1'b1;
        default: ;
      endcase
    end
  end

  // R3: in the normal layout a loaded low field is never zero
  a_r3_low_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lowLd && MULTICART == 0) |-> (strobe.lowVal != 5'd0));

endmodule

// File: rtl/cart_bank_path.sv
module cart_bank_path
  import cart_bank_pkg::*;
#(
  parameter int ROM_BW   = 6,
  parameter int RAM_BW   = 2,
  parameter int UP_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strobe,
  input  logic [2:0]        cpuRegion,
  output logic [ROM_BW-1:0] romBank,
  output logic [RAM_BW-1:0] ramBank,
  output logic              romSel,
  output logic              ramSel,
  output logic              ramBlank
);

  localparam int FULL_W = UP_SHIFT + 2;

  logic [4:0]        lowBits;
  logic [1:0]        upperBits;
  logic              modeBit;
  logic              ramEn;
  logic [FULL_W-1:0] switchFull;
  logic [FULL_W-1:0] baseFull;
  logic [ROM_BW-1:0] switchBank;
  logic [ROM_BW-1:0] baseBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowBits   <= 5'd1;
      upperBits <= 2'd0;
      modeBit   <= 1'b0;
      ramEn     <= 1'b0;
    end else begin
      if (strobe.lowLd)   lowBits   <= strobe.lowVal;
      if (strobe.upperLd) upperBits <= strobe.upperVal;
      if (strobe.modeLd)  modeBit   <= strobe.modeVal;
      if (strobe.ramOn)       ramEn <= 1'b1;
      else if (strobe.ramOff) ramEn <= 1'b0;
    end
  end

  always_comb begin
    switchFull = (FULL_W'(upperBits) << UP_SHIFT) | FULL_W'(lowBits);
    baseFull   = modeBit ? (FULL_W'(upperBits) << UP_SHIFT) : '0;
    switchBank = ROM_BW'(switchFull);   // wrap against ROM size
    baseBank   = ROM_BW'(baseFull);
    romBank    = cpuRegion[1] ? switchBank : baseBank;
    ramBank    = modeBit ? RAM_BW'(upperBits) : '0;
    romSel     = !cpuRegion[2];
    ramSel     = (cpuRegion == REGION_RAMWIN) && ramEn;
    ramBlank   = (cpuRegion == REGION_RAMWIN) && !ramEn;
  end

  // R2: the enable moves only on a decoded enable or disable code
  a_r2_ram_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.ramOn || strobe.ramOff) |=> $stable(ramEn));
  a_r2_ram_on: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ramOn |=> ramEn);
  // R10: without any load strobe no state changes
  a_r10_no_strobe_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.ramOn || strobe.ramOff || strobe.lowLd || strobe.upperLd || strobe.modeLd)
    |=> $stable({lowBits, upperBits, modeBit, ramEn}));

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  parameter int RAM_BANKS = 4,
  parameter int MULTICART = 0,
  localparam int ROM_BW   = $clog2(ROM_BANKS),
  localparam int RAM_BW   = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        cpuRegion,
  input  logic [7:0]        wrData,
  output logic [ROM_BW-1:0] romBank,
  output logic [RAM_BW-1:0] ramBank,
  output logic              romSel,
  output logic              ramSel,
  output logic              ramBlank
);

  localparam int UP_SHIFT = (MULTICART != 0) ? 4 : 5;

  bankStrobe_t strobe;

  cart_bank_decode #(.MULTICART(MULTICART)) u_decode (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .cpuRegion(cpuRegion),
    .wrData(wrData), .strobe(strobe)
  );

  cart_bank_path #(.ROM_BW(ROM_BW), .RAM_BW(RAM_BW), .UP_SHIFT(UP_SHIFT)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuRegion(cpuRegion),
    .romBank(romBank), .ramBank(ramBank), .romSel(romSel),
    .ramSel(ramSel), .ramBlank(ramBlank)
  );

  // R9: access and blanking of the RAM window are never both signalled
  a_r9_window_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(ramSel && ramBlank));

endmodule

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] cpuRegion = 3'd0;
  logic [7:0] wrData = 8'd0;

  logic [5:0] romBank;
  logic [1:0] ramBank;
  logic romSel, ramSel, ramBlank;
  logic [4:0] mcRomBank;
  logic [0:0] mcRamBank;
  logic mcRomSel, mcRamSel, mcRamBlank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cart_bank_ctrl #(.ROM_BANKS(64), .RAM_BANKS(4), .MULTICART(0)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .cpuRegion(cpuRegion), .wrData(wrData),
    .romBank(romBank), .ramBank(ramBank), .romSel(romSel), .ramSel(ramSel),
    .ramBlank(ramBlank)
  );

  cart_bank_ctrl #(.ROM_BANKS(32), .RAM_BANKS(2), .MULTICART(1)) u_dutMc (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .cpuRegion(cpuRegion), .wrData(wrData),
    .romBank(mcRomBank), .ramBank(mcRamBank), .romSel(mcRomSel), .ramSel(mcRamSel),
    .ramBlank(mcRamBlank)
  );

  // {wrRegion, wrData, rdRegion, expRom, expRam, expRamSel, expRamBlank}
  localparam logic [23:0] VEC [NVEC] = '{
    {3'd1, 8'h00, 3'd2, 6'd1,  2'd0, 1'b0, 1'b0},  // R3 zero becomes 1
    {3'd1, 8'h13, 3'd2, 6'd19, 2'd0, 1'b0, 1'b0},  // R3
    {3'd1, 8'hE5, 3'd2, 6'd5,  2'd0, 1'b0, 1'b0},  // R3 bits 7:5 dropped
    {3'd1, 8'h20, 3'd2, 6'd1,  2'd0, 1'b0, 1'b0},  // R3 remap before mask
    {3'd2, 8'h01, 3'd2, 6'd33, 2'd0, 1'b0, 1'b0},  // R4
    {3'd4, 8'hFF, 3'd0, 6'd0,  2'd0, 1'b0, 1'b0},  // R10 / R6
    {3'd3, 8'h01, 3'd0, 6'd32, 2'd1, 1'b0, 1'b0},  // R5
    {3'd2, 8'hFE, 3'd1, 6'd0,  2'd2, 1'b0, 1'b0},  // R7 bank 64 wraps to 0
    {3'd2, 8'h03, 3'd3, 6'd33, 2'd3, 1'b0, 1'b0},  // R4 97 wraps to 33
    {3'd0, 8'h0A, 3'd5, 6'd32, 2'd3, 1'b1, 1'b0},  // R2 enable
    {3'd0, 8'h05, 3'd5, 6'd32, 2'd3, 1'b1, 1'b0},  // R2 other code
    {3'd0, 8'h1A, 3'd5, 6'd32, 2'd3, 1'b1, 1'b0},  // R2 near code
    {3'd0, 8'h00, 3'd5, 6'd32, 2'd3, 1'b0, 1'b1},  // R9 disabled window
    {3'd3, 8'hFE, 3'd0, 6'd0,  2'd0, 1'b0, 1'b0},  // R6 mode 0
    {3'd3, 8'h03, 3'd2, 6'd33, 2'd3, 1'b0, 1'b0},  // R8 mode 1 again
    {3'd6, 8'h0A, 3'd5, 6'd32, 2'd3, 1'b0, 1'b1},  // R10 region 6
    {3'd7, 8'h00, 3'd2, 6'd33, 2'd3, 1'b0, 1'b0}   // R10 region 7
  };

  localparam string VEC_TAG [NVEC] = '{
    "R3", "R3", "R3", "R3", "R4", "R10", "R5", "R7", "R4",
    "R2", "R2", "R2", "R9", "R6", "R8", "R10", "R10"
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] r, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    cpuRegion = r;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readAt(input logic [2:0] r);
    cpuRegion = r;
    #1;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    applyReset();

    // R1 reset state, R8 and R9 selects
    readAt(3'd2);
    check("R1", "switch bank", romBank, 1);
    check("R1", "mc switch bank", mcRomBank, 1);
    readAt(3'd0);
    check("R1", "low region bank", romBank, 0);
    check("R1", "ram bank", ramBank, 0);
    check("R8", "romSel region 0", romSel, 1);
    readAt(3'd5);
    check("R1", "ram disabled blank", ramBlank, 1);
    check("R9", "ramSel disabled", ramSel, 0);
    check("R8", "romSel region 5", romSel, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] v;
      v = VEC[i];
      doWrite(v[23:21], v[20:13]);
      readAt(v[12:10]);
      check(VEC_TAG[i], $sformatf("row %0d romBank", i), romBank, int'(v[9:4]));
      check(VEC_TAG[i], $sformatf("row %0d ramBank", i), ramBank, int'(v[3:2]));
      check(VEC_TAG[i], $sformatf("row %0d ramSel", i), ramSel, int'(v[1]));
      check(VEC_TAG[i], $sformatf("row %0d ramBlank", i), ramBlank, int'(v[0]));
      check("R8", $sformatf("row %0d romSel", i), romSel, int'(v[12:10] < 3'd4));
    end

    // R10: cycle with wrEn low leaves the switchable bank as it was (33)
    @(negedge clk);
    cpuRegion = 3'd1;
    wrData = 8'h07;
    @(negedge clk);
    readAt(3'd2);
    check("R10", "wrEn low ignored", romBank, 33);

    // Multi-game layout with a second reset
    applyReset();
    doWrite(3'd1, 8'h10);
    readAt(3'd2);
    check("R3", "mc 0x10 masks to 0", mcRomBank, 0);
    check("R3", "normal 0x10 stays 16", romBank, 16);
    doWrite(3'd1, 8'h00);
    readAt(3'd2);
    check("R3", "mc zero becomes 1", mcRomBank, 1);
    doWrite(3'd2, 8'h01);
    readAt(3'd2);
    check("R4", "mc shift 4", mcRomBank, 17);
    check("R4", "normal shift 5", romBank, 33);
    doWrite(3'd2, 8'h02);
    readAt(3'd2);
    check("R7", "mc bank 33 wraps to 1", mcRomBank, 1);
    readAt(3'd0);
    check("R6", "mc low region mode 0", mcRomBank, 0);
    doWrite(3'd3, 8'h01);
    readAt(3'd0);
    check("R7", "mc low region 32 wraps to 0", mcRomBank, 0);
    check("R7", "mc ram bank 2 wraps to 0", mcRamBank, 0);
    doWrite(3'd2, 8'h03);
    readAt(3'd0);
    check("R5", "mc low region 48 wraps to 16", mcRomBank, 16);
    check("R5", "mc ram bank", mcRamBank, 1);
    check("R5", "normal low region", romBank, 32);
    check("R5", "normal ram bank", ramBank, 3);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule